// File: doc/BRIEF.md
# Sprite and Palette RAM Access Redirector

This block sits between the CPU byte port and two small on-chip memories of a video renderer: the sprite attribute store (544 bytes, a 512-byte main table plus a 32-byte high table) and the palette store (512 bytes). It cleans up the CPU address for each memory. The sprite address is cut to 10 bits, and the upper half folds onto the 32-byte high table. The palette address is cut to 9 bits. Odd palette bytes keep only 7 significant bits.

While the picture is being drawn and forced blank is off, the renderer owns the sprite store. Any CPU access in that time lands on the address the renderer is currently using, not on the address the CPU gave. A palette redirect mode, off unless its enable input is set, does the same for the palette store inside a dot window of each drawn line. In that case the byte is clipped to 7 bits.

Every sprite write is reported one cycle later as a change record with the effective address and data. The write also drops a "sprite list valid" flag, which a separate rebuild-done strobe raises again. Both memories are synchronous single-port arrays with a one-cycle read latency.

Top module: `spal_access_top`

## Requirements
- R1: The sprite address in use is the low 10 bits of the CPU address. When bit 9 of that value is 1, bits 8 to 5 are cleared, so addresses 0x200 to 0x3FF map onto 0x200 to 0x21F. The renderer's sprite address is folded the same way.
- R2: With force_blank high, sprite reads and writes use the folded CPU address, whatever the line counter shows.
- R3: With force_blank low and line_cnt below 225 (below 240 when overscan is high), sprite reads and writes use the folded renderer address. From line 225 (or 240) upward, they use the CPU address.
- R4: Read data appears on the read port one clock after a request with the write enable low. It holds its value on cycles with no read. Both read ports reset to 0x00.
- R5: A sprite write pulses spr_chg_valid for exactly one cycle, on the cycle after the write, with spr_chg_addr and spr_chg_data equal to the effective address and byte written. There is no pulse otherwise.
- R6: spr_list_valid is 1 after reset. It goes to 0 on the cycle after any sprite write. It returns to 1 on the cycle after a rebuild_done pulse. A write in the same cycle as rebuild_done wins.
- R7: The palette address in use is the low 9 bits of the CPU address.
- R8: When the 9-bit palette CPU address is odd, bit 7 is written as 0 and read back as 0.
- R9: With pal_redir_en high, force_blank low, the line active as in R3, and dot_cnt from 128 to 1095 inclusive, palette accesses use rend_pal_addr and the byte is clipped to 7 bits on write and on read.
- R10: With pal_redir_en low, palette accesses always use the CPU address, on any line and dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cnt | input | 9 | Current line counter |
| dot_cnt | input | 11 | Current dot counter |
| overscan | input | 1 | Drawn area extends to 240 lines |
| force_blank | input | 1 | Display forced off |
| pal_redir_en | input | 1 | Enable palette redirect mode |
| rend_spr_addr | input | 10 | Renderer's current sprite address |
| rend_pal_addr | input | 9 | Renderer's current palette address |
| spr_req | input | 1 | Sprite access request |
| spr_we | input | 1 | Sprite access is a write |
| spr_addr | input | 16 | CPU sprite byte address |
| spr_wdata | input | 8 | Sprite write byte |
| spr_rdata | output | 8 | Sprite read byte |
| pal_req | input | 1 | Palette access request |
| pal_we | input | 1 | Palette access is a write |
| pal_addr | input | 16 | CPU palette byte address |
| pal_wdata | input | 8 | Palette write byte |
| pal_rdata | output | 8 | Palette read byte |
| rebuild_done | input | 1 | Sprite list rebuilt strobe |
| spr_chg_valid | output | 1 | Sprite change record valid |
| spr_chg_addr | output | 10 | Effective address of last sprite write |
| spr_chg_data | output | 8 | Byte of last sprite write |
| spr_list_valid | output | 1 | Sprite list up to date |

## Verification
The assertions take the request, write-enable and strobe inputs as held low throughout reset. They also take the counters as stable around each clock edge, so a value seen in one cycle is the one the access used. The address checks only look at the main-table range, where folding leaves the address unchanged. The bench drives every input at the falling edge and keeps all strobes at zero during reset. It fills both memories with forced blank before it reads anything, so every read compares against a defined byte.

// File: rtl/spal_pkg.sv
package spal_pkg;
  localparam int DW           = 8;
  localparam int SPR_AW       = 10;
  localparam int SPR_MAIN     = 512;
  localparam int SPR_HIGH     = 32;
  localparam int SPR_DEPTH    = SPR_MAIN + SPR_HIGH;
  localparam int PAL_AW       = 9;
  localparam int PAL_DEPTH    = 1 << PAL_AW;

  // Fold the upper half of the sprite space onto the 32-byte high table.
  function automatic logic [SPR_AW-1:0] spr_fold(input logic [SPR_AW-1:0] a);
    logic [SPR_AW-1:0] r;
    r = a;
    if (a[SPR_AW-1]) r[SPR_AW-2:5] = '0;
    return r;
  endfunction

  // Clear the top bit of a byte when asked.
  function automatic logic [DW-1:0] clip7(input logic [DW-1:0] d, input logic clip);
    return clip ? {1'b0, d[DW-2:0]} : d;
  endfunction
endpackage

// File: rtl/spal_timing.sv
module spal_timing #(
  parameter int LINE_W         = 9,
  parameter int DOT_W          = 11,
  parameter int LINES_NORMAL   = 225,
  parameter int LINES_OVERSCAN = 240,
  parameter int DOT_FIRST      = 128,
  parameter int DOT_LAST       = 1095,
  parameter int PAL_REDIR_IMPL = 1
) (
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [DOT_W-1:0]  dot_cnt,
  input  logic              overscan,
  input  logic              force_blank,
  input  logic              pal_redir_en,
  output logic              disp_active,
  output logic              pal_window
);
  localparam logic [LINE_W-1:0] LIM_N  = LINE_W'(LINES_NORMAL);
  localparam logic [LINE_W-1:0] LIM_O  = LINE_W'(LINES_OVERSCAN);
  localparam logic [DOT_W-1:0]  DOT_LO = DOT_W'(DOT_FIRST);
  localparam logic [DOT_W-1:0]  DOT_HI = DOT_W'(DOT_LAST);

  function automatic logic line_drawn(input logic [LINE_W-1:0] l, input logic ovs);
    return l < (ovs ? LIM_O : LIM_N);
  endfunction

  function automatic logic dot_inside(input logic [DOT_W-1:0] d);
    return (d >= DOT_LO) && (d <= DOT_HI);
  endfunction

  assign disp_active = !force_blank && line_drawn(line_cnt, overscan);

  generate
    if (PAL_REDIR_IMPL != 0) begin : g_pal_redir
      assign pal_window = pal_redir_en && disp_active && dot_inside(dot_cnt);
    end else begin : g_no_pal_redir
      logic unused_redir;
      assign unused_redir = pal_redir_en ^ (^dot_cnt);
      assign pal_window   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/spal_byte_ram.sv
module spal_byte_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rdata <= '0;
    else if (en && !we)    rdata <= mem[addr];
  end
endmodule

// File: rtl/spal_list_tracker.sv
module spal_list_tracker #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rebuild_done,
  output logic          chg_valid,
  output logic [AW-1:0] chg_addr,
  output logic [DW-1:0] chg_data,
  output logic          list_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_valid  <= 1'b0;
      chg_addr   <= '0;
      chg_data   <= '0;
      list_valid <= 1'b1;
    end else begin
      chg_valid <= wr_evt;
      if (wr_evt) begin
        chg_addr   <= wr_addr;
        chg_data   <= wr_data;
        list_valid <= 1'b0;
      end else if (rebuild_done) begin
        list_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spal_access_top.sv
module spal_access_top
  import spal_pkg::*;
#(
  parameter int LINE_W         = 9,
  parameter int DOT_W          = 11,
  parameter int CPU_AW         = 16,
  parameter int LINES_NORMAL   = 225,
  parameter int LINES_OVERSCAN = 240,
  parameter int DOT_FIRST      = 128,
  parameter int DOT_LAST       = 1095,
  parameter int PAL_REDIR_IMPL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LINE_W-1:0]   line_cnt,
  input  logic [DOT_W-1:0]    dot_cnt,
  input  logic                overscan,
  input  logic                force_blank,
  input  logic                pal_redir_en,
  input  logic [SPR_AW-1:0]   rend_spr_addr,
  input  logic [PAL_AW-1:0]   rend_pal_addr,
  input  logic                spr_req,
  input  logic                spr_we,
  input  logic [CPU_AW-1:0]   spr_addr,
  input  logic [DW-1:0]       spr_wdata,
  output logic [DW-1:0]       spr_rdata,
  input  logic                pal_req,
  input  logic                pal_we,
  input  logic [CPU_AW-1:0]   pal_addr,
  input  logic [DW-1:0]       pal_wdata,
  output logic [DW-1:0]       pal_rdata,
  input  logic                rebuild_done,
  output logic                spr_chg_valid,
  output logic [SPR_AW-1:0]   spr_chg_addr,
  output logic [DW-1:0]       spr_chg_data,
  output logic                spr_list_valid
);
  // Named internal events, brought out for the checker.
  logic              disp_active;
  logic              pal_window;
  logic [SPR_AW-1:0] spr_cpu_fold;
  logic [SPR_AW-1:0] spr_eff_addr;
  logic              spr_wr_evt;
  logic [PAL_AW-1:0] pal_cpu_idx;
  logic [PAL_AW-1:0] pal_eff_addr;
  logic              pal_redir_hit;
  logic              pal_clip;
  logic [DW-1:0]     pal_wdata_eff;
  logic [DW-1:0]     pal_raw_q;
  logic              pal_clip_q;
  logic              unused_cpu_hi;

  assign unused_cpu_hi = ^{spr_addr[CPU_AW-1:SPR_AW], pal_addr[CPU_AW-1:PAL_AW]};

  spal_timing #(
    .LINE_W        (LINE_W),
    .DOT_W         (DOT_W),
    .LINES_NORMAL  (LINES_NORMAL),
    .LINES_OVERSCAN(LINES_OVERSCAN),
    .DOT_FIRST     (DOT_FIRST),
    .DOT_LAST      (DOT_LAST),
    .PAL_REDIR_IMPL(PAL_REDIR_IMPL)
  ) u_timing (
    .line_cnt    (line_cnt),
    .dot_cnt     (dot_cnt),
    .overscan    (overscan),
    .force_blank (force_blank),
    .pal_redir_en(pal_redir_en),
    .disp_active (disp_active),
    .pal_window  (pal_window)
  );

  // Sprite path: the renderer owns the store while the picture is drawn.
  assign spr_cpu_fold = spr_fold(spr_addr[SPR_AW-1:0]);
  assign spr_eff_addr = disp_active ? spr_fold(rend_spr_addr) : spr_cpu_fold;
  assign spr_wr_evt   = spr_req && spr_we;

  spal_byte_ram #(.DEPTH(SPR_DEPTH), .DW(DW)) u_spr_ram (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (spr_req),
    .we   (spr_we),
    .addr (spr_eff_addr),
    .wdata(spr_wdata),
    .rdata(spr_rdata)
  );

  spal_list_tracker #(.AW(SPR_AW), .DW(DW)) u_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_evt      (spr_wr_evt),
    .wr_addr     (spr_eff_addr),
    .wr_data     (spr_wdata),
    .rebuild_done(rebuild_done),
    .chg_valid   (spr_chg_valid),
    .chg_addr    (spr_chg_addr),
    .chg_data    (spr_chg_data),
    .list_valid  (spr_list_valid)
  );

  // Palette path: optional redirect window, odd-byte clip.
  assign pal_cpu_idx   = pal_addr[PAL_AW-1:0];
  assign pal_redir_hit = pal_req && pal_window;
  assign pal_eff_addr  = pal_window ? rend_pal_addr : pal_cpu_idx;
  assign pal_clip      = pal_window || pal_cpu_idx[0];
  assign pal_wdata_eff = clip7(pal_wdata, pal_clip);

  spal_byte_ram #(.DEPTH(PAL_DEPTH), .DW(DW)) u_pal_ram (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (pal_req),
    .we   (pal_we),
    .addr (pal_eff_addr),
    .wdata(pal_wdata_eff),
    .rdata(pal_raw_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pal_clip_q <= 1'b0;
    else if (pal_req && !pal_we) pal_clip_q <= pal_clip;
  end

  assign pal_rdata = clip7(pal_raw_q, pal_clip_q);
endmodule

// File: rtl/spal_checker.sv
module spal_checker #(
  parameter int LINE_W       = 9,
  parameter int LINES_NORMAL = 225
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINE_W-1:0] line_cnt,
  input logic              force_blank,
  input logic              pal_redir_en,
  input logic [9:0]        rend_spr_addr,
  input logic              spr_req,
  input logic              spr_we,
  input logic [15:0]       spr_addr,
  input logic [7:0]        spr_rdata,
  input logic              pal_req,
  input logic              pal_we,
  input logic [15:0]       pal_addr,
  input logic [7:0]        pal_rdata,
  input logic              rebuild_done,
  input logic              spr_chg_valid,
  input logic [9:0]        spr_chg_addr,
  input logic              spr_list_valid,
  input logic              pal_redir_hit
);
  localparam logic [LINE_W-1:0] LIM_N = LINE_W'(LINES_NORMAL);

  assert_chg_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_req && spr_we) |=> spr_chg_valid);

  assert_no_spurious_chg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(spr_req && spr_we) |=> !spr_chg_valid);

  assert_chg_addr_folded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spr_chg_valid |-> (!spr_chg_addr[9] || (spr_chg_addr[8:5] == 4'd0)));

  assert_list_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_req && spr_we) |=> !spr_list_valid);

  assert_list_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rebuild_done && !(spr_req && spr_we)) |=> spr_list_valid);

  assert_blank_uses_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_req && spr_we && force_blank && !spr_addr[9])
      |=> (spr_chg_addr == $past(spr_addr[9:0])));

  assert_active_uses_rend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_req && spr_we && !force_blank && (line_cnt < LIM_N) && !rend_spr_addr[9])
      |=> (spr_chg_addr == $past(rend_spr_addr)));

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(spr_req && !spr_we) |=> $stable(spr_rdata));

  assert_odd_read_clipped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_req && !pal_we && pal_addr[0]) |=> !pal_rdata[7]);

  assert_redir_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pal_redir_hit |-> (pal_redir_en && !force_blank));
endmodule

bind spal_access_top spal_checker #(
  .LINE_W      (LINE_W),
  .LINES_NORMAL(LINES_NORMAL)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_cnt      (line_cnt),
  .force_blank   (force_blank),
  .pal_redir_en  (pal_redir_en),
  .rend_spr_addr (rend_spr_addr),
  .spr_req       (spr_req),
  .spr_we        (spr_we),
  .spr_addr      (spr_addr),
  .spr_rdata     (spr_rdata),
  .pal_req       (pal_req),
  .pal_we        (pal_we),
  .pal_addr      (pal_addr),
  .pal_rdata     (pal_rdata),
  .rebuild_done  (rebuild_done),
  .spr_chg_valid (spr_chg_valid),
  .spr_chg_addr  (spr_chg_addr),
  .spr_list_valid(spr_list_valid),
  .pal_redir_hit (pal_redir_hit)
);

// File: tb/spal_access_top_bench.sv
`timescale 1ns/1ps
module spal_access_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  line_cnt = '0;
  logic [10:0] dot_cnt = '0;
  logic        overscan = 1'b0, force_blank = 1'b1, pal_redir_en = 1'b0;
  logic [9:0]  rend_spr_addr = '0;
  logic [8:0]  rend_pal_addr = '0;
  logic        spr_req = 1'b0, spr_we = 1'b0, pal_req = 1'b0, pal_we = 1'b0;
  logic [15:0] spr_addr = '0, pal_addr = '0;
  logic [7:0]  spr_wdata = '0, pal_wdata = '0;
  logic        rebuild_done = 1'b0;
  logic [7:0]  spr_rdata, pal_rdata, spr_chg_data;
  logic [9:0]  spr_chg_addr;
  logic        spr_chg_valid, spr_list_valid;

  always #4 clk = ~clk;   // 125 MHz

  spal_access_top u_spal_access_top (
    .clk(clk), .rst_n(rst_n), .line_cnt(line_cnt), .dot_cnt(dot_cnt),
    .overscan(overscan), .force_blank(force_blank), .pal_redir_en(pal_redir_en),
    .rend_spr_addr(rend_spr_addr), .rend_pal_addr(rend_pal_addr),
    .spr_req(spr_req), .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
    .spr_rdata(spr_rdata), .pal_req(pal_req), .pal_we(pal_we), .pal_addr(pal_addr),
    .pal_wdata(pal_wdata), .pal_rdata(pal_rdata), .rebuild_done(rebuild_done),
    .spr_chg_valid(spr_chg_valid), .spr_chg_addr(spr_chg_addr),
    .spr_chg_data(spr_chg_data), .spr_list_valid(spr_list_valid)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // Reference model state.
  logic [7:0] m_spr [544];
  logic [7:0] m_pal [512];
  logic [7:0] e_spr_rd = 8'h00, e_pal_rd = 8'h00, e_cd = 8'h00;
  logic [9:0] e_ca = '0;
  logic       e_cv = 1'b0, e_lv = 1'b1;

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int spr_index(input int a);
    int r = a % 1024;
    if (r >= 512) r = 512 + (r % 32);
    return r;
  endfunction

  function automatic bit drawn_line();
    return !force_blank && (int'(line_cnt) < (overscan ? 240 : 225));
  endfunction

  task automatic model_step();
    int se, pa, pe;
    bit redir, clip;
    se = drawn_line() ? spr_index(int'(rend_spr_addr)) : spr_index(int'(spr_addr));
    if (spr_req && spr_we) begin
      m_spr[se] = spr_wdata;
      e_cv = 1'b1; e_ca = 10'(se); e_cd = spr_wdata; e_lv = 1'b0;
    end else begin
      e_cv = 1'b0;
      if (rebuild_done) e_lv = 1'b1;
      if (spr_req) e_spr_rd = m_spr[se];
    end
    pa    = int'(pal_addr) % 512;
    redir = pal_redir_en && drawn_line() && dot_cnt >= 128 && dot_cnt <= 1095;
    pe    = redir ? int'(rend_pal_addr) : pa;
    clip  = redir || (pa % 2 == 1);
    if (pal_req && pal_we)  m_pal[pe] = clip ? 8'(pal_wdata % 128) : pal_wdata;
    else if (pal_req)       e_pal_rd  = clip ? 8'(m_pal[pe] % 128) : m_pal[pe];
  endtask

  task automatic compare();
    check("R4 spr_rdata", spr_rdata, e_spr_rd);
    check("R4 pal_rdata", pal_rdata, e_pal_rd);
    check("R5 spr_chg_valid", spr_chg_valid, e_cv);
    if (e_cv) begin
      check("R5 spr_chg_addr", spr_chg_addr, e_ca);
      check("R5 spr_chg_data", spr_chg_data, e_cd);
    end
    check("R6 spr_list_valid", spr_list_valid, e_lv);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    spr_req = 0; spr_we = 0; pal_req = 0; pal_we = 0; rebuild_done = 0;
  endtask

  task automatic ctx(input int ln, input int dt, input bit ovs, input bit blank, input bit ren);
    line_cnt = 9'(ln); dot_cnt = 11'(dt); overscan = ovs; force_blank = blank; pal_redir_en = ren;
  endtask

  task automatic spr_wr(input int a, input int d);
    spr_req = 1; spr_we = 1; spr_addr = 16'(a); spr_wdata = 8'(d); cyc();
  endtask
  task automatic spr_rd(input int a);
    spr_req = 1; spr_we = 0; spr_addr = 16'(a); cyc();
  endtask
  task automatic pal_wr(input int a, input int d);
    pal_req = 1; pal_we = 1; pal_addr = 16'(a); pal_wdata = 8'(d); cyc();
  endtask
  task automatic pal_rd(input int a);
    pal_req = 1; pal_we = 0; pal_addr = 16'(a); cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 544; i++) m_spr[i] = 8'h00;
    for (int i = 0; i < 512; i++) m_pal[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: R4, R5, R6.
    check("R4 reset spr_rdata", spr_rdata, 0);
    check("R4 reset pal_rdata", pal_rdata, 0);
    check("R5 reset chg_valid", spr_chg_valid, 0);
    check("R6 reset list_valid", spr_list_valid, 1);

    // Fill both stores under forced blank.
    ctx(0, 0, 0, 1, 0);
    for (int i = 0; i < 544; i++) spr_wr((i < 512) ? i : (512 + (i - 512)), (i * 7 + 3) % 256);
    for (int i = 0; i < 512; i++) pal_wr(i, (i * 13 + 200) % 256);

    // R1: folding of the sprite address.
    spr_wr(16'hFC05, 8'h5A);
    check("R1 chg_addr mask", spr_chg_addr, 10'h005);
    spr_rd(16'h0005);
    check("R1 read masked", spr_rdata, 8'h5A);
    spr_wr(16'h03E5, 8'hC3);
    check("R1 chg_addr fold", spr_chg_addr, 10'h205);
    spr_rd(16'h0205);
    check("R1 read folded", spr_rdata, 8'hC3);

    // R2: forced blank on a drawn line uses the CPU address.
    ctx(10, 300, 0, 1, 0);
    rend_spr_addr = 10'h100;
    spr_wr(16'h0040, 8'h11);
    check("R2 chg_addr cpu", spr_chg_addr, 10'h040);
    spr_rd(16'h0040);
    check("R2 read cpu", spr_rdata, 8'h11);

    // R3: drawn-line boundaries, normal and overscan.
    rend_spr_addr = 10'h101;
    ctx(224, 300, 0, 0, 0); spr_wr(16'h0041, 8'h22);
    check("R3 line 224 rend", spr_chg_addr, 10'h101);
    ctx(225, 300, 0, 0, 0); spr_wr(16'h0042, 8'h33);
    check("R3 line 225 cpu", spr_chg_addr, 10'h042);
    ctx(239, 300, 1, 0, 0); spr_wr(16'h0043, 8'h44);
    check("R3 ovs line 239 rend", spr_chg_addr, 10'h101);
    ctx(240, 300, 1, 0, 0); spr_wr(16'h0044, 8'h55);
    check("R3 ovs line 240 cpu", spr_chg_addr, 10'h044);
    ctx(100, 300, 0, 0, 0); rend_spr_addr = 10'h3F1; spr_rd(16'h0000);
    check("R3 read rend folded", spr_rdata, m_spr[10'h211]);

    // R6: rebuild strobe, and write winning over it.
    rebuild_done = 1; cyc();
    check("R6 set by rebuild", spr_list_valid, 1);
    rebuild_done = 1; spr_wr(16'h0001, 8'h01);
    check("R6 write wins", spr_list_valid, 0);

    // R7, R8: palette masking and odd clip.
    ctx(0, 0, 0, 1, 0);
    pal_wr(16'hFE04, 8'h44); pal_rd(16'h0004);
    check("R7 pal mask", pal_rdata, 8'h44);
    pal_wr(16'h0007, 8'hFF); pal_rd(16'h0007);
    check("R8 odd clip", pal_rdata, 8'h7F);

    // R9: redirect window edges.
    rend_pal_addr = 9'h020;
    ctx(5, 128, 0, 0, 1); pal_wr(16'h0010, 8'h9C);
    ctx(0, 0, 0, 1, 0);   pal_rd(16'h0020);
    check("R9 dot 128 redirected", pal_rdata, 8'h1C);
    ctx(5, 127, 0, 0, 1); pal_wr(16'h0010, 8'hA6);
    ctx(0, 0, 0, 1, 0);   pal_rd(16'h0010);
    check("R9 dot 127 cpu", pal_rdata, 8'hA6);
    ctx(5, 1095, 0, 0, 1); pal_wr(16'h0012, 8'hF0);
    ctx(0, 0, 0, 1, 0);   pal_rd(16'h0020);
    check("R9 dot 1095 redirected", pal_rdata, 8'h70);
    ctx(5, 1096, 0, 0, 1); pal_wr(16'h0014, 8'hE1);
    ctx(0, 0, 0, 1, 0);   pal_rd(16'h0014);
    check("R9 dot 1096 cpu", pal_rdata, 8'hE1);

    // R10: mode disabled keeps the CPU address.
    ctx(5, 500, 0, 0, 0); pal_wr(16'h0030, 8'h9C);
    pal_rd(16'h0030);
    check("R10 disabled cpu", pal_rdata, 8'h9C);

    // Mixed stimulus against the model on every clock.
    for (int n = 0; n < 6000; n++) begin
      ctx($urandom_range(261), $urandom_range(1363), $urandom_range(1),
          ($urandom_range(3) == 0), $urandom_range(1));
      rend_spr_addr = 10'($urandom);
      rend_pal_addr = 9'($urandom);
      spr_req = $urandom_range(1); spr_we = $urandom_range(1);
      spr_addr = 16'($urandom); spr_wdata = 8'($urandom);
      pal_req = $urandom_range(1); pal_we = $urandom_range(1);
      pal_addr = 16'($urandom); pal_wdata = 8'($urandom);
      rebuild_done = ($urandom_range(3) == 0);
      cyc();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule